// File: doc/BRIEF.md
# Iterative Floating-Point Divider

This block divides one 32-bit floating-point word by another. The operand word carries a sign bit, an 8-bit exponent stored with an offset of 128 and a 23-bit fraction with an implied leading one. The sign and exponent of the quotient are formed directly. The 24-bit significand quotient comes from a non-restoring divider that yields one quotient bit per clock. That quotient is normalized, truncated and packed. An exponent that is too large saturates to the largest magnitude. An exponent that is too small flushes to zero.

A controller raises `req` with both operands applied. The block samples the operands on that edge and computes. It then raises `done` with `result` valid, and holds both until the controller drops `req`. The pins carry a plain control handshake and have no back-pressure of their own. The controller throttles by keeping `req` high or low. The block accepts the next request only after `done` has fallen. It never drops a result: the result stays in place until the next acceptance.

Top module: `nr_fp_divider`

## Requirements
- R1: Word layout: bit 31 is the sign, bits 30:23 are the exponent (value = 1.fraction × 2^(exponent−128)), and bits 22:0 are the fraction. An exponent field of 0 denotes zero. Every zero result is the all-zero word 32'h0000_0000.
- R2: For non-zero operands in range, the result sign is the XOR of the operand signs. The result fraction is the truncated quotient of the two significands, normalized to the form 1.f.
- R3: The result exponent is dividend exponent − divisor exponent + 128. It is one lower when the dividend significand is smaller than the divisor significand.
- R4: `done` first reads high after the 27th rising edge, where the edge that samples `req` high in the idle state counts as the first.
- R5: While `done` is high and `req` stays high, `done` stays high. After the first edge that sees `req` low, `done` is low. A request is accepted only when `done` is low.
- R6: A result exponent above 255 gives {sign, 8'hFF, 23'h7FFFFF}. An exponent of exactly 255 is returned unsaturated.
- R7: A result exponent of 0 or below gives 32'h0000_0000. An exponent of exactly 1 is returned as a normal number.
- R8: A zero dividend with a non-zero divisor gives 32'h0000_0000.
- R9: A zero divisor gives {XOR of signs, 8'hFF, 23'h7FFFFF}. This holds even when the dividend is also zero.
- R10: `result` is unchanged from the rise of `done` until the next request completes, and also after `req` falls.
- R11: The block uses only the operand values present on the accepting edge. Later changes on `dividend` and `divisor` have no effect on that result.
- R12: After reset, `done` is low and `result` is 32'h0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request; held high until `done` is seen |
| dividend | input | 32 | Numerator word |
| divisor | input | 32 | Denominator word |
| result | output | 32 | Quotient word, valid while `done` is high |
| done | output | 1 | Result ready; falls after `req` is released |

## Verification
A corrupted partial remainder or a wrong add/subtract choice shows as a wrong fraction bit in `result` on the same `done` pulse that completes the request. Low-order bits expose faults that begin late in the iteration. An iteration counter that is off by one moves the rise of `done` by a cycle and shifts every fraction bit, so it is caught on the very first request. A controller stuck in its completion state shows within one cycle of `req` falling, because `done` stays high.

// File: rtl/nrfd_pkg.sv
package nrfd_pkg;
  localparam int EXP_W_DEF = 8;
  localparam int MAN_W_DEF = 23;
  localparam int BIAS_DEF  = 128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/nrfd_unpack.sv
module nrfd_unpack #(
  parameter int EXP_W = nrfd_pkg::EXP_W_DEF,
  parameter int MAN_W = nrfd_pkg::MAN_W_DEF
) (
  input  logic [EXP_W+MAN_W:0] word,
  output logic                 sign,
  output logic [EXP_W-1:0]     expo,
  output logic [MAN_W:0]       sig,
  output logic                 is_zero
);
  // field split; the implied leading one is restored here
  assign sign    = word[EXP_W+MAN_W];
  assign expo    = word[EXP_W+MAN_W-1:MAN_W];
  assign sig     = {1'b1, word[MAN_W-1:0]};
  assign is_zero = (expo == '0);
endmodule

// File: rtl/nrfd_nrdiv.sv
module nrfd_nrdiv #(
  parameter int SIG_W = nrfd_pkg::MAN_W_DEF + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SIG_W-1:0] num,
  input  logic [SIG_W-1:0] den,
  output logic [SIG_W:0]   quo,
  output logic             fin
);
  localparam int QW = SIG_W + 1;          // quotient bits: one extra for normalization
  localparam int RW = SIG_W + 3;          // signed partial remainder width
  localparam int CW = $clog2(QW + 1);
  localparam logic [CW-1:0] LAST = CW'(QW - 1);

  logic signed [RW-1:0] rem_q, shifted, den_ext, rem_nx;
  logic [QW-1:0]        quo_q;
  logic [SIG_W-1:0]     den_q;
  logic [CW-1:0]        cnt_q;
  logic                 busy_q, fin_q;
  logic                 qbit;

  always_comb begin
    shifted = (cnt_q == '0) ? rem_q : (rem_q <<< 1);
    den_ext = $signed({3'b000, den_q});
    // negative remainder: add divisor back; otherwise subtract it
    rem_nx  = rem_q[RW-1] ? (shifted + den_ext) : (shifted - den_ext);
    qbit    = ~rem_nx[RW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (start) begin
      rem_q  <= $signed({3'b000, num});
      den_q  <= den;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_nx;
      quo_q <= {quo_q[QW-2:0], qbit};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;
endmodule

// File: rtl/nrfd_pack.sv
module nrfd_pack #(
  parameter int EXP_W = nrfd_pkg::EXP_W_DEF,
  parameter int MAN_W = nrfd_pkg::MAN_W_DEF,
  parameter int BIAS  = nrfd_pkg::BIAS_DEF
) (
  input  logic                 sign,
  input  logic [EXP_W-1:0]     exp_a,
  input  logic [EXP_W-1:0]     exp_b,
  input  logic                 zero_a,
  input  logic                 zero_b,
  input  logic [MAN_W+1:0]     quo,
  output logic [EXP_W+MAN_W:0] word
);
  localparam int QW = MAN_W + 2;
  localparam int XW = EXP_W + 2;
  localparam logic signed [XW-1:0] BIAS_S  = XW'(BIAS);
  localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] EXP_ONE = XW'(1);

  logic signed [XW-1:0] exp_raw;
  logic [MAN_W-1:0]     mant;
  logic [EXP_W+MAN_W:0] sat_word;

  always_comb begin
    // top quotient bit set: significand ratio >= 1, drop it as hidden one
    mant     = quo[QW-1] ? quo[QW-2:1] : quo[QW-3:0];
    exp_raw  = $signed({2'b00, exp_a}) - $signed({2'b00, exp_b}) + BIAS_S
             - $signed({{(XW-1){1'b0}}, ~quo[QW-1]});
    sat_word = {sign, {(EXP_W+MAN_W){1'b1}}};
    if (zero_b)                word = sat_word;
    else if (zero_a)           word = '0;
    else if (exp_raw > EXP_TOP) word = sat_word;
    else if (exp_raw < EXP_ONE) word = '0;
    else                       word = {sign, exp_raw[EXP_W-1:0], mant};
  end
endmodule

// File: rtl/nr_fp_divider.sv
module nr_fp_divider #(
  parameter int EXP_W = nrfd_pkg::EXP_W_DEF,
  parameter int MAN_W = nrfd_pkg::MAN_W_DEF,
  parameter int BIAS  = nrfd_pkg::BIAS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [EXP_W+MAN_W:0] dividend,
  input  logic [EXP_W+MAN_W:0] divisor,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 done
);
  import nrfd_pkg::*;

  localparam int WW    = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;

  ctl_state_t state_q;

  logic             sa, sb, za, zb;
  logic [EXP_W-1:0] ea, eb;
  logic [SIG_W-1:0] siga, sigb;

  logic             sign_q, za_q, zb_q;
  logic [EXP_W-1:0] ea_q, eb_q;
  logic [SIG_W:0]   quo;
  logic             fin, start;
  logic [WW-1:0]    packed_w, result_q;

  nrfd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_unp_a (
    .word(dividend), .sign(sa), .expo(ea), .sig(siga), .is_zero(za));
  nrfd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_unp_b (
    .word(divisor), .sign(sb), .expo(eb), .sig(sigb), .is_zero(zb));

  assign start = (state_q == ST_IDLE) && req;

  nrfd_nrdiv #(.SIG_W(SIG_W)) i_div (
    .clk(clk), .rst_n(rst_n), .start(start),
    .num(siga), .den(sigb), .quo(quo), .fin(fin));

  nrfd_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) i_pack (
    .sign(sign_q), .exp_a(ea_q), .exp_b(eb_q),
    .zero_a(za_q), .zero_b(zb_q), .quo(quo), .word(packed_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sign_q   <= 1'b0;
      za_q     <= 1'b0;
      zb_q     <= 1'b0;
      ea_q     <= '0;
      eb_q     <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req) begin
          sign_q  <= sa ^ sb;
          ea_q    <= ea;
          eb_q    <= eb;
          za_q    <= za;
          zb_q    <= zb;
          state_q <= ST_RUN;
        end
        ST_RUN: if (fin) begin
          result_q <= packed_w;
          state_q  <= ST_HOLD;
        end
        ST_HOLD: if (!req) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result = result_q;
  assign done   = (state_q == ST_HOLD);
endmodule

// File: rtl/nr_fp_divider_chk.sv
module nr_fp_divider_chk #(
  parameter int WW    = 32,
  parameter int SIG_W = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          done,
  input logic [WW-1:0] result,
  input logic          start,
  input logic          sign_q
);
  localparam int LAT = SIG_W + 3;   // accept edge, iterations, pack edge
  logic [7:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_q <= '0;
    else if (start)                lat_q <= 8'd1;
    else if (lat_q != '0 && !done) lat_q <= lat_q + 8'd1;
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lat_q == 8'(LAT));
  a_r5_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> done);
  a_r5_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> !done);
  a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(result));
  a_r1_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (result[WW-2:WW-9] == 8'h00) |-> (result == '0));
  a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != '0) |-> (result[WW-1] == sign_q));
endmodule

bind nr_fp_divider nr_fp_divider_chk #(.WW(1 + EXP_W + MAN_W), .SIG_W(MAN_W + 1)) i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done),
  .result(result), .start(start), .sign_q(sign_q));

// File: tb/test_nr_fp_divider.sv
module test_nr_fp_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic [31:0] result;
  logic        done;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  nr_fp_divider i_nr_fp_divider (
    .clk(clk), .rst_n(rst_n), .req(req), .dividend(dividend),
    .divisor(divisor), .result(result), .done(done));

  function automatic [31:0] mk(input bit s, input int e, input int m);
    return {s, e[7:0], m[22:0]};
  endfunction

  // reference from the requirements: excess-128 exponent, truncated fraction
  function automatic [31:0] model(input [31:0] a, input [31:0] b);
    bit s = a[31] ^ b[31];
    longint na, nb, q;
    int e;
    logic [22:0] m;
    if (b[30:23] == 0) return {s, 31'h7FFF_FFFF};
    if (a[30:23] == 0) return 32'h0;
    na = {1'b1, a[22:0]};
    nb = {1'b1, b[22:0]};
    q  = (na << 24) / nb;
    e  = int'(a[30:23]) - int'(b[30:23]) + 128;
    if (q >= (64'd1 << 24)) m = q[23:1];
    else begin m = q[22:0]; e = e - 1; end
    if (e > 255) return {s, 31'h7FFF_FFFF};
    if (e <= 0) return 32'h0;
    return {s, e[7:0], m};
  endfunction

  task automatic check(input bit ok, input string tag, input [31:0] act, input [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one request: latency, value, hold, release
  task automatic run_div(input [31:0] a, input [31:0] b, input [31:0] expv, input string tag);
    int n = 0;
    bit got = 0;
    @(negedge clk);
    dividend = a; divisor = b; req = 1'b1;
    while (!got && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 1) begin dividend = ~a; divisor = 32'h0; end  // R11: late change ignored
      if (done) got = 1;
    end
    check(got && n == 27, "R4 latency", n, 27);
    check(result == expv, tag, result, expv);
    @(negedge clk);
    check(done == 1'b1, "R5 held", done, 1);
    req = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R5 release", done, 0);
    check(result == expv, "R10 stable", result, expv);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R12 done", done, 0);
    check(result == 32'h0, "R12 result", result, 0);
  endtask

  task automatic t_basic();
    run_div(mk(0,128,0), mk(0,128,0), 32'h4000_0000, "R2 one/one");
    run_div(32'h40C0_0000, 32'h4080_0000, 32'h4040_0000, "R2 three/two");
    run_div(mk(1,130,32'h400000), mk(0,129,0), 32'hC0C0_0000, "R2 sign");
    run_div(mk(0,128,0), mk(0,128,32'h400000), 32'h3FAA_AAAA, "R3 smaller significand");
    run_div(mk(0,140,32'h123456), mk(1,120,32'h7ABCDE), model(mk(0,140,32'h123456), mk(1,120,32'h7ABCDE)), "R11 operands sampled once");
  endtask

  task automatic t_range();
    run_div(mk(1,250,0), mk(0,2,0), 32'hFFFF_FFFF, "R6 overflow");
    run_div(mk(0,255,0), mk(0,127,0), 32'h7FFF_FFFF, "R6 just above");
    run_div(mk(0,255,32'h100000), mk(0,128,0), 32'h7F90_0000, "R6 exactly top");
    run_div(mk(0,1,0), mk(0,128,0), 32'h0080_0000, "R7 exactly one");
    run_div(mk(0,1,0), mk(0,128,32'h400000), 32'h0, "R7 just below");
    run_div(mk(0,2,0), mk(1,250,0), 32'h0, "R7 underflow");
  endtask

  task automatic t_zero();
    run_div(32'h0, mk(0,130,0), 32'h0, "R8 zero dividend");
    run_div(mk(1,0,32'h123456), mk(0,130,0), 32'h0, "R8 R1 zero with fraction");
    run_div(mk(1,130,0), mk(0,0,0), 32'hFFFF_FFFF, "R9 zero divisor");
    run_div(32'h0, 32'h0, 32'h7FFF_FFFF, "R9 both zero");
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      a[30:23] = 8'(($urandom % 200) + 28);
      b[30:23] = 8'(($urandom % 200) + 28);
      run_div(a, b, model(a, b), "R2 R3 random");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_range();
    t_zero();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule